// File: doc/BRIEF.md
# SIMD Floating-Point Compare-Against-Zero Unit

This unit takes a 128-bit operand and compares every floating-point lane in it against positive zero. It returns one mask per lane: all ones when the selected relation holds and all zeros when it does not. The operand can hold half (16-bit), single (32-bit) or double (64-bit) lanes. The unit can work on one element (scalar mode) or on a 64-bit or 128-bit vector. Five relations are available. The two "less" relations are evaluated as "zero greater than element" and "zero greater-or-equal element".

The unit raises three flags. The invalid-operation flag covers NaN operands. The input-denormal flag covers subnormal lanes that are flushed to zero. The undefined flag covers reserved or unsupported encodings. Only lanes inside the operating width take part. A decoder upstream drives the control fields together with an `in_valid` strobe, and the result appears one clock later on registered outputs.

Top module: `fp_zero_cmp`

## Requirements
- R1: Each active lane of `mask` is all ones when the selected relation between the lane value and +0 holds, and all zeros otherwise.
- R2: `op_sel` encodes 0 = greater-than, 1 = greater-or-equal, 2 = equal, 3 = less-or-equal (zero ≥ element), 4 = less-than (zero > element). Codes 5 to 7 raise `undef_flag`.
- R3: Lane width is 16 when `half_sel`=1. Otherwise it is 32 when `size_bit`=0 and 64 when `size_bit`=1. Lane l occupies mask and operand bits [l*W +: W].
- R4: In vector mode, `wide_q`=1 gives a 128-bit operating width and `wide_q`=0 gives a 64-bit width. Mask bits 127:64 are zero when `wide_q`=0.
- R5: In scalar mode only lane 0 is compared, and every mask bit above that lane is zero.
- R6: Vector mode with `half_sel`=0, `size_bit`=1 and `wide_q`=0 is reserved and raises `undef_flag`. The scalar double form is not reserved.
- R7: `half_sel`=1 while `half_ok`=0 raises `undef_flag`. Whenever `undef_flag` is set, `mask`, `invalid_flag` and `denorm_flag` are zero.
- R8: Negative zero equals positive zero. For -0, equal, greater-or-equal and less-or-equal are true, and less-than and greater-than are false.
- R9: A NaN lane fails every relation. Ordered relations (codes 0, 1, 3, 4) raise `invalid_flag` for any NaN. Equal raises it only for a signalling NaN, which has the top fraction bit clear.
- R10: With `ftz`=1 a subnormal lane compares as a zero of its sign and raises `denorm_flag`. With `ftz`=0 a subnormal lane compares by its sign as a non-zero value, and `denorm_flag` stays low.
- R11: The flags are the OR over active lanes only. Lanes outside the operating width never set them.
- R12: Outputs are registered with one cycle of latency. `out_valid` follows `in_valid`. Results hold while `in_valid` is low. Reset clears all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| opnd | input | 128 | Source operand |
| op_sel | input | 3 | Relation select |
| half_sel | input | 1 | Half-precision lanes |
| size_bit | input | 1 | 0: single, 1: double (when not half) |
| wide_q | input | 1 | 1: 128-bit vector, 0: 64-bit vector |
| scalar_mode | input | 1 | 1: one element only |
| half_ok | input | 1 | Half precision permitted |
| ftz | input | 1 | Flush subnormal inputs to zero |
| out_valid | output | 1 | Result valid |
| mask | output | 128 | Per-lane all-ones/all-zeros result |
| invalid_flag | output | 1 | Invalid-operation flag |
| denorm_flag | output | 1 | Input-denormal flag |
| undef_flag | output | 1 | Undefined encoding |

## Verification
The assertions check five things on every cycle. Reserved and unsupported encodings always give `undef_flag`, and an undefined result never carries a mask or an exception flag. Narrow and scalar results keep the upper half of `mask` clear. The denormal flag appears only under flush-to-zero. `out_valid` tracks the request. The bench scenarios cover everything that depends on lane values: each relation against signed zeros, quiet and signalling NaNs, and subnormals with and without flushing, in every lane format. They also check that flags from lanes outside the operating width are ignored.

// File: rtl/fp_zero_cmp.sv
module fp_zero_cmp (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [127:0] opnd,
  input  logic [2:0]   op_sel,
  input  logic         half_sel,
  input  logic         size_bit,
  input  logic         wide_q,
  input  logic         scalar_mode,
  input  logic         half_ok,
  input  logic         ftz,
  output logic         out_valid,
  output logic [127:0] mask,
  output logic         invalid_flag,
  output logic         denorm_flag,
  output logic         undef_flag
);

  localparam logic [2:0] OP_GT = 3'd0;
  localparam logic [2:0] OP_GE = 3'd1;
  localparam logic [2:0] OP_EQ = 3'd2;
  localparam logic [2:0] OP_LE = 3'd3;
  localparam logic [2:0] OP_LT = 3'd4;

  logic [2:0][7:0]   hit_f, inv_f, den_f, act_f;
  logic [2:0][127:0] exp_f;
  logic [1:0]        fsel;
  logic              undef_c;

  assign fsel = half_sel ? 2'd0 : (size_bit ? 2'd2 : 2'd1);

  for (genvar f = 0; f < 3; f++) begin : g_fmt
    localparam int EW = (f == 0) ? 5 : ((f == 1) ? 8 : 11);
    localparam int FW = (f == 0) ? 10 : ((f == 1) ? 23 : 52);
    localparam int W  = 1 + EW + FW;
    localparam int N  = 128 / W;
    for (genvar l = 0; l < 8; l++) begin : g_lane
      if (l < N) begin : g_live
        logic [W-1:0] e;
        logic sgn, ex_max, ex_min, frac_nz, nan, snan, zero_like;
        logic gt_ez, ge_ez, gt_ze, ge_ze, eq_z, pass;
        assign e         = opnd[l*W +: W];
        assign sgn       = e[W-1];
        assign ex_max    = &e[W-2:FW];
        assign ex_min    = ~|e[W-2:FW];
        assign frac_nz   = |e[FW-1:0];
        assign nan       = ex_max & frac_nz;
        assign snan      = nan & ~e[FW-1];
        assign zero_like = ex_min & (~frac_nz | ftz);
        // element vs zero, and zero vs element (operands swapped)
        assign gt_ez = ~nan & ~sgn & ~zero_like;
        assign ge_ez = ~nan & (~sgn | zero_like);
        assign gt_ze = ~nan & sgn & ~zero_like;
        assign ge_ze = ~nan & (sgn | zero_like);
        assign eq_z  = ~nan & zero_like;
        assign pass  = (op_sel == OP_GT) ? gt_ez :
                       (op_sel == OP_GE) ? ge_ez :
                       (op_sel == OP_EQ) ? eq_z  :
                       (op_sel == OP_LE) ? ge_ze :
                       (op_sel == OP_LT) ? gt_ze : 1'b0;
        assign act_f[f][l] = scalar_mode ? 1'(l == 0) : (wide_q | 1'(l < N/2));
        assign hit_f[f][l] = pass & act_f[f][l];
        assign inv_f[f][l] = act_f[f][l] & ((op_sel == OP_EQ) ? snan : nan);
        assign den_f[f][l] = act_f[f][l] & ftz & ex_min & frac_nz;
        assign exp_f[f][l*W +: W] = {W{hit_f[f][l]}};
      end else begin : g_dead
        assign act_f[f][l] = 1'b0;
        assign hit_f[f][l] = 1'b0;
        assign inv_f[f][l] = 1'b0;
        assign den_f[f][l] = 1'b0;
      end
    end
  end

  assign undef_c = (op_sel > OP_LT) | (half_sel & ~half_ok) |
                   (~half_sel & size_bit & ~wide_q & ~scalar_mode);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      mask         <= '0;
      invalid_flag <= 1'b0;
      denorm_flag  <= 1'b0;
      undef_flag   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        undef_flag   <= undef_c;
        mask         <= undef_c ? '0 : exp_f[fsel];
        invalid_flag <= ~undef_c & |inv_f[fsel];
        denorm_flag  <= ~undef_c & |den_f[fsel];
      end
    end
  end

  p_valid_follow_r12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));
  p_undef_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    undef_flag |-> (mask == '0 && !invalid_flag && !denorm_flag));
  p_reserved_dbl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(!half_sel && size_bit && !wide_q && !scalar_mode)) |-> undef_flag);
  p_half_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(half_sel && !half_ok)) |-> undef_flag);
  p_bad_op_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(op_sel > 3'd4)) |-> undef_flag);
  p_narrow_upper_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(!wide_q)) |-> (mask[127:64] == '0));
  p_scalar_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(scalar_mode)) |-> (mask[127:64] == '0));
  p_denorm_ftz_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(denorm_flag) |-> $past(ftz));

endmodule

// File: tb/tb_fp_zero_cmp.sv
module tb_fp_zero_cmp;
  logic clk = 0, rst_n = 0, in_valid = 0;
  logic [127:0] opnd = '0;
  logic [2:0] op_sel = '0;
  logic half_sel = 0, size_bit = 0, wide_q = 0, scalar_mode = 0, half_ok = 1, ftz = 0;
  logic out_valid, invalid_flag, denorm_flag, undef_flag;
  logic [127:0] mask;

  fp_zero_cmp dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opnd(opnd), .op_sel(op_sel),
    .half_sel(half_sel), .size_bit(size_bit), .wide_q(wide_q), .scalar_mode(scalar_mode),
    .half_ok(half_ok), .ftz(ftz), .out_valid(out_valid), .mask(mask),
    .invalid_flag(invalid_flag), .denorm_flag(denorm_flag), .undef_flag(undef_flag));

  always #10 clk = ~clk;

  int vectors = 0, errors = 0;
  bit have_prev = 0;
  string e_tag;
  logic [127:0] e_mask = '0;
  bit e_valid = 0, e_inv = 0, e_den = 0, e_und = 0;

  function automatic void model(input logic [127:0] x, input int op, input bit hs, sb, wq, sc, hok, fz,
                                output logic [127:0] m, output bit inv, den, und);
    int esz, ew, fw, lanes;
    logic [127:0] lm;
    m = '0; inv = 0; den = 0;
    und = (op > 4) || (hs && !hok) || (!hs && sb && !wq && !sc);
    if (und) return;
    esz = hs ? 16 : (sb ? 64 : 32);
    ew  = hs ? 5 : (sb ? 11 : 8);
    fw  = esz - 1 - ew;
    lanes = sc ? 1 : ((wq ? 128 : 64) / esz);
    lm = (128'd1 << esz) - 128'd1;
    for (int e = 0; e < lanes; e++) begin
      logic [63:0] v;
      longint unsigned expo, frac;
      bit s, nan, quiet, zero, pass;
      int val;
      v = 64'((x >> (e * esz)) & lm);
      s = v[esz-1];
      expo = (v >> fw) & ((64'd1 << ew) - 1);
      frac = v & ((64'd1 << fw) - 1);
      nan = (expo == (64'd1 << ew) - 1) && (frac != 0);
      quiet = ((frac >> (fw - 1)) & 1) != 0;
      zero = (expo == 0) && (frac == 0 || fz);
      if (expo == 0 && frac != 0 && fz) den = 1;
      val = zero ? 0 : (s ? -1 : 1);
      case (op)
        0: pass = val > 0;
        1: pass = val >= 0;
        2: pass = val == 0;
        3: pass = val <= 0;
        default: pass = val < 0;
      endcase
      if (nan) begin
        pass = 0;
        if (op != 2 || !quiet) inv = 1;
      end
      if (pass) m |= lm << (e * esz);
    end
  endfunction

  task automatic check_prev();
    if (!have_prev) return;
    vectors++;
    if (out_valid !== e_valid || mask !== e_mask || invalid_flag !== e_inv ||
        denorm_flag !== e_den || undef_flag !== e_und) begin
      errors++;
      $display("FAIL %s: got v=%b m=%h inv=%b den=%b und=%b exp v=%b m=%h inv=%b den=%b und=%b",
               e_tag, out_valid, mask, invalid_flag, denorm_flag, undef_flag,
               e_valid, e_mask, e_inv, e_den, e_und);
    end
  endtask

  task automatic vec(input string tag, input logic [127:0] x, input int op,
                     input bit hs, sb, wq, sc, hok, fz);
    logic [127:0] m; bit i, d, u;
    @(negedge clk);
    check_prev();
    in_valid = 1; opnd = x; op_sel = 3'(op); half_sel = hs; size_bit = sb;
    wide_q = wq; scalar_mode = sc; half_ok = hok; ftz = fz;
    model(x, op, hs, sb, wq, sc, hok, fz, m, i, d, u);
    e_tag = tag; e_valid = 1; e_mask = m; e_inv = i; e_den = d; e_und = u; have_prev = 1;
  endtask

  task automatic idle(input string tag);
    @(negedge clk);
    check_prev();
    in_valid = 0; opnd = {4{32'hDEADBEEF}};
    e_tag = tag; e_valid = 0; have_prev = 1;
  endtask

  function automatic logic [15:0] pick16();
    logic [15:0] pool [11] = '{16'h0000, 16'h8000, 16'h3C00, 16'hBC00, 16'h7C00, 16'hFC00,
                               16'h7E00, 16'h7C01, 16'h0001, 16'h8001, 16'h7BFF};
    if ($urandom_range(0, 3) == 0) return 16'($urandom);
    return pool[$urandom_range(0, 10)];
  endfunction

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: run hung, exp completion got timeout");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  localparam logic [127:0] HMIX = {16'h8001, 16'h0001, 16'h7C01, 16'h7E00,
                                   16'h8000, 16'h0000, 16'hBC00, 16'h3C00};

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    vectors++;
    if (out_valid !== 0 || mask !== '0 || invalid_flag !== 0 || denorm_flag !== 0 || undef_flag !== 0) begin
      errors++;
      $display("FAIL R12 reset: got v=%b m=%h exp all zero", out_valid, mask);
    end
    e_tag = "R12"; e_valid = 0; have_prev = 1;

    for (int op = 0; op < 5; op++) vec("R2 half ops", HMIX, op, 1, 0, 1, 0, 1, 0);
    for (int op = 0; op < 5; op++) vec("R10 ftz on", HMIX, op, 1, 0, 1, 0, 1, 1);
    vec("R8 neg zero eq", {112'h0, 16'h8000}, 2, 1, 0, 0, 1, 1, 0);
    vec("R8 neg zero lt", {112'h0, 16'h8000}, 4, 1, 0, 0, 1, 1, 0);
    vec("R8 neg zero ge", {112'h0, 16'h8000}, 1, 1, 0, 0, 1, 1, 0);
    vec("R9 qnan eq", {64'h0, 16'h7E00, 16'h0, 16'h8000, 16'h0}, 2, 1, 0, 0, 0, 1, 0);
    vec("R9 snan eq", {64'h0, 16'h7D00, 16'h0, 16'h8000, 16'h0}, 2, 1, 0, 0, 0, 1, 0);
    vec("R9 qnan gt", {64'h0, 16'h7E00, 16'h0, 16'h3C00, 16'h0}, 0, 1, 0, 0, 0, 1, 0);
    vec("R3 single 4S", {32'h7FC00000, 32'h80000000, 32'hC0000000, 32'h3F800000}, 1, 0, 0, 1, 0, 1, 0);
    vec("R3 double 2D", {64'h8000000000000000, 64'h3FF0000000000000}, 3, 0, 1, 1, 0, 1, 0);
    vec("R3 double lt", {64'hBFF0000000000000, 64'h3FF0000000000000}, 4, 0, 1, 1, 0, 1, 0);
    vec("R4 narrow 2S", {32'hC0000000, 32'hC0000000, 32'hBF800000, 32'h3F800000}, 4, 0, 0, 0, 0, 1, 0);
    vec("R11 upper nan ignored", {{4{16'h7C01}}, {4{16'h3C00}}}, 0, 1, 0, 0, 0, 1, 0);
    vec("R11 upper den ignored", {{4{16'h0001}}, {4{16'h3C00}}}, 0, 1, 0, 0, 0, 1, 1);
    vec("R5 scalar double", {64'hBFF0000000000000, 64'h3FF0000000000000}, 0, 0, 1, 0, 1, 1, 0);
    vec("R5 scalar single", {96'hFFFFFFFF_FFFFFFFF_FFFFFFFF, 32'hBF800000}, 4, 0, 0, 1, 1, 1, 0);
    vec("R6 reserved 2D narrow", {64'h0, 64'hBFF0000000000000}, 4, 0, 1, 0, 0, 1, 0);
    vec("R6 scalar double ok", {64'h0, 64'hBFF0000000000000}, 4, 0, 1, 0, 1, 1, 0);
    vec("R7 half disabled", HMIX, 3, 1, 0, 1, 0, 0, 1);
    vec("R2 bad op code", HMIX, 6, 1, 0, 1, 0, 1, 0);
    vec("R10 single den noftz", {96'h0, 32'h80000001}, 4, 0, 0, 0, 1, 1, 0);
    vec("R10 single den ftz", {96'h0, 32'h80000001}, 4, 0, 0, 0, 1, 1, 1);
    vec("R1 all pos gt", {8{16'h3C00}}, 0, 1, 0, 1, 0, 1, 0);
    idle("R12 hold");
    idle("R12 hold");
    e_valid = 0;

    for (int k = 0; k < 400; k++) begin
      logic [127:0] x;
      for (int c = 0; c < 8; c++) x[c*16 +: 16] = pick16();
      if ((k % 17) == 5) idle("R12 idle");
      vec("R1 random", x, $urandom_range(0, 5), $urandom_range(0, 1), $urandom_range(0, 1),
          $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 7) != 0, $urandom_range(0, 1));
    end
    idle("R12 final");
    @(negedge clk);
    check_prev();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule